// File: doc/BRIEF.md
# IDE Register Window Unlock Controller

This block sits on the I/O decode of an IDE command-block window and decides where each byte offset of that window lands. Normally every access is forwarded to the task-file registers. A fixed three-access key sequence switches the whole window over to a hidden bank of timing and control registers. A single lock write switches it back.

While the bank is open, software chooses a device with the miscellaneous register, loads that device's read-cycle and write-cycle timing bytes, and sets an address-setup code that both devices share. A commit write to the control register then copies both staged timing sets and the setup code onto the registered timing outputs that feed the drive cycle generator. A read-only strap register reports which bus clock the board runs at. The bus port is synchronous and returns read data one cycle after the read strobe.

Top module: `ide_bank_gate`

## Requirements
- R1: After reset the bank is closed (`bank_open` = 0), the timing outputs and `act_setup` are all zero, and the detector waits for the first key step.
- R2: The bank opens on the edge that samples this exact sequence of accesses: a 16-bit read (`bus_wide`=1) at offset 1, another 16-bit read at offset 1, then an 8-bit write (`bus_wide`=0) with low data byte 0x03 at offset 2.
- R3: While closed, any access other than the expected next step (other offset, width, direction or data value) returns the detector to its first step. A 16-bit read at offset 1 that breaks the sequence counts as a new first step.
- R4: While closed, `tf_rd`/`tf_wr` follow `bus_rd`/`bus_wr` in the same cycle, and `bus_rdata` returns the value of `tf_rdata` sampled at the read, one cycle after the read strobe.
- R5: While open, `tf_rd` and `tf_wr` stay 0 and reads return bank data one cycle later. Offsets 2, 3, 4 and 7 read as zero.
- R6: A write at offset 6 takes data bit 0 as the selected device and data bits 7:1 as the shared setup code. A read of offset 6 returns {setup, device}.
- R7: Writes at offset 0 (read timing) and offset 1 (write timing) store the low data byte into the selected device's staged set. Reads at offsets 0 and 1 return the selected device's staged bytes.
- R8: An 8-bit write of 0x85 at offset 3 copies both staged sets and the staged setup code onto `act_rd_tim`, `act_wr_tim` and `act_setup`, with device d in bits [8d+7:8d]. No other access changes those outputs.
- R9: A read at offset 5 returns the `strap_clk` input in bit 0 (0 = 33 MHz bus clock, 1 = 25 MHz) with all other bits zero. Writes at offset 5 have no effect.
- R10: While open, only an 8-bit write of 0x83 at offset 2 closes the bank. Other values or a 16-bit write at offset 2 leave it open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Byte offset within the window |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| tf_rd | output | 1 | Read forwarded to the task file |
| tf_wr | output | 1 | Write forwarded to the task file |
| tf_rdata | input | 16 | Task-file read data for the current offset |
| strap_clk | input | 1 | Bus clock strap, 0 = 33 MHz, 1 = 25 MHz |
| bank_open | output | 1 | Hidden bank is mapped into the window |
| act_rd_tim | output | 16 | Committed read timing, one byte per device |
| act_wr_tim | output | 16 | Committed write timing, one byte per device |
| act_setup | output | 7 | Committed shared address-setup code |

## Verification
Two functions can fall in the same cycle: an access that breaks the key sequence can also be a valid first step of a new sequence. This happens when a third 16-bit read at offset 1 arrives where the key write was due. The bench provokes it by running every width, direction and offset as the breaking access after zero, one and two valid steps, and by repeating wide reads before the key write. A bench model of the sequence decides whether the key write that follows opens the bank, and the check reads `bank_open`. The commit and its staging writes are judged only on the timing outputs, which are sampled before and after each commit.

// File: rtl/ide_bank_pkg.sv
// ide_bank_pkg: offsets, key codes and sequence states shared by the
// IDE window unlock controller. Assumes an 8-bit key/register byte.
package ide_bank_pkg;
    localparam logic [2:0] OFS_RTIM  = 3'd0;  // read-cycle timing
    localparam logic [2:0] OFS_WTIM  = 3'd1;  // write-cycle timing, also key probe
    localparam logic [2:0] OFS_GATE  = 3'd2;  // unlock / lock key port
    localparam logic [2:0] OFS_CTRL  = 3'd3;  // commit control
    localparam logic [2:0] OFS_STRAP = 3'd5;  // clock strap, read-only
    localparam logic [2:0] OFS_MISC  = 3'd6;  // device select + setup code

    localparam logic [7:0] KEY_OPEN   = 8'h03;
    localparam logic [7:0] KEY_SHUT   = 8'h83;
    localparam logic [7:0] KEY_COMMIT = 8'h85;

    typedef enum logic [1:0] {SQ_IDLE, SQ_ONE, SQ_TWO} seq_t;
endpackage

// File: rtl/ide_unlock_seq.sv
// ide_unlock_seq: watches window accesses for the open key sequence
// (two wide reads at offset 1, byte write 0x03 at offset 2) and keeps the
// bank-open flag. Assumes rd and wr are never high together.
module ide_unlock_seq
    import ide_bank_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_rd,
    input  logic          acc_wr,
    input  logic          acc_wide,
    input  logic [AW-1:0] acc_addr,
    input  logic [7:0]    acc_byte,
    output logic          open_o
);
    seq_t st_q;
    logic open_q;
    logic step_hit, key_hit, shut_hit, any_acc;

    // Decode of the individual key steps.
    always_comb begin
        any_acc  = acc_rd | acc_wr;
        step_hit = acc_rd & acc_wide & (acc_addr == AW'(OFS_WTIM));
        key_hit  = acc_wr & ~acc_wide & (acc_addr == AW'(OFS_GATE)) & (acc_byte == KEY_OPEN);
        shut_hit = acc_wr & ~acc_wide & (acc_addr == AW'(OFS_GATE)) & (acc_byte == KEY_SHUT);
    end

    // Sequence state and open flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            open_q <= 1'b0;
        end else if (open_q) begin
            st_q <= SQ_IDLE;
            if (shut_hit) open_q <= 1'b0;
        end else if (any_acc) begin
            case (st_q)
                SQ_IDLE: st_q <= step_hit ? SQ_ONE : SQ_IDLE;
                SQ_ONE:  st_q <= step_hit ? SQ_TWO : SQ_IDLE;
                default: begin
                    if (key_hit) begin
                        open_q <= 1'b1;
                        st_q   <= SQ_IDLE;
                    end else begin
                        st_q <= step_hit ? SQ_ONE : SQ_IDLE;
                    end
                end
            endcase
        end
    end

    assign open_o = open_q;

    // R2
    property key_open_p;
        @(posedge clk) disable iff (!rst_n)
        (!open_q && st_q == SQ_TWO && key_hit) |=> open_q;
    endproperty
    key_open_chk: assert property (key_open_p);

    // R3
    property seq_break_p;
        @(posedge clk) disable iff (!rst_n)
        (!open_q && any_acc && !step_hit) |=> (st_q == SQ_IDLE);
    endproperty
    seq_break_chk: assert property (seq_break_p);

    // R10
    property shut_p;
        @(posedge clk) disable iff (!rst_n)
        (open_q && shut_hit) |=> !open_q;
    endproperty
    shut_chk: assert property (shut_p);

    // R10
    property stay_open_p;
        @(posedge clk) disable iff (!rst_n)
        (open_q && !shut_hit) |=> open_q;
    endproperty
    stay_open_chk: assert property (stay_open_p);
endmodule

// File: rtl/ide_timing_bank.sv
// ide_timing_bank: hidden register bank with per-device staged timing,
// shared setup code, commit to active outputs and strap readback.
// Assumes writes arrive only while the bank is open (we gated outside).
module ide_timing_bank
    import ide_bank_pkg::*;
#(
    parameter int AW   = 3,
    parameter int NDEV = 2,
    parameter int TW   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic               wide,
    input  logic [AW-1:0]      addr,
    input  logic [TW-1:0]      wbyte,
    input  logic               strap,
    output logic [TW-1:0]      rd_val,
    output logic [NDEV*TW-1:0] act_rd_o,
    output logic [NDEV*TW-1:0] act_wr_o,
    output logic [TW-SELW-1:0] act_setup_o
);
    localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam int SUW  = TW - SELW;

    logic [NDEV-1:0][TW-1:0] stage_rd, stage_wr, act_rd, act_wr;
    logic [SELW-1:0]         sel_q;
    logic [SUW-1:0]          setup_q, act_setup;
    logic                    commit;

    // Commit decode: byte write of the commit key at the control offset.
    assign commit = we & ~wide & (addr == AW'(OFS_CTRL)) & (wbyte == TW'(KEY_COMMIT));

    // Staged registers, device select and committed copies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_rd  <= '0;
            stage_wr  <= '0;
            act_rd    <= '0;
            act_wr    <= '0;
            sel_q     <= '0;
            setup_q   <= '0;
            act_setup <= '0;
        end else if (we) begin
            for (int d = 0; d < NDEV; d++) begin
                if (sel_q == SELW'(d) && addr == AW'(OFS_RTIM)) stage_rd[d] <= wbyte;
                if (sel_q == SELW'(d) && addr == AW'(OFS_WTIM)) stage_wr[d] <= wbyte;
            end
            if (addr == AW'(OFS_MISC)) begin
                sel_q   <= wbyte[SELW-1:0];
                setup_q <= wbyte[TW-1:SELW];
            end
            if (commit) begin
                act_rd    <= stage_rd;
                act_wr    <= stage_wr;
                act_setup <= setup_q;
            end
        end
    end

    // Read multiplexer over the bank offsets.
    always_comb begin
        case (addr)
            AW'(OFS_RTIM):  rd_val = stage_rd[sel_q];
            AW'(OFS_WTIM):  rd_val = stage_wr[sel_q];
            AW'(OFS_STRAP): rd_val = {{(TW-1){1'b0}}, strap};
            AW'(OFS_MISC):  rd_val = {setup_q, sel_q};
            default:        rd_val = '0;
        endcase
    end

    // Flatten the committed sets onto the output buses.
    for (genvar d = 0; d < NDEV; d++) begin : g_out
        assign act_rd_o[d*TW +: TW] = act_rd[d];
        assign act_wr_o[d*TW +: TW] = act_wr[d];
    end
    assign act_setup_o = act_setup;

    // R8
    property hold_p;
        @(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_rd) && $stable(act_wr) && $stable(act_setup));
    endproperty
    hold_chk: assert property (hold_p);

    // R8
    property commit_p;
        @(posedge clk) disable iff (!rst_n)
        commit |=> (act_rd == $past(stage_rd) && act_wr == $past(stage_wr));
    endproperty
    commit_chk: assert property (commit_p);
endmodule

// File: rtl/ide_bank_gate.sv
// ide_bank_gate: top of the IDE window unlock controller. Routes window
// accesses to the task file while closed and to the hidden timing bank
// while open; registers read data with one cycle of latency.
// Assumes DW > TW and one strobe per access cycle.
module ide_bank_gate #(
    parameter int AW   = 3,
    parameter int DW   = 16,
    parameter int NDEV = 2,
    parameter int TW   = 8,
    localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_wide,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               tf_rd,
    output logic               tf_wr,
    input  logic [DW-1:0]      tf_rdata,
    input  logic               strap_clk,
    output logic               bank_open,
    output logic [NDEV*TW-1:0] act_rd_tim,
    output logic [NDEV*TW-1:0] act_wr_tim,
    output logic [TW-SELW-1:0] act_setup
);
    logic          open_w;
    logic [TW-1:0] bank_val;
    logic [DW-1:0] rdata_q;

    ide_unlock_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_rd   (bus_rd),
        .acc_wr   (bus_wr),
        .acc_wide (bus_wide),
        .acc_addr (bus_addr),
        .acc_byte (bus_wdata[7:0]),
        .open_o   (open_w)
    );

    ide_timing_bank #(.AW(AW), .NDEV(NDEV), .TW(TW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (bus_wr & open_w),
        .wide        (bus_wide),
        .addr        (bus_addr),
        .wbyte       (bus_wdata[TW-1:0]),
        .strap       (strap_clk),
        .rd_val      (bank_val),
        .act_rd_o    (act_rd_tim),
        .act_wr_o    (act_wr_tim),
        .act_setup_o (act_setup)
    );

    // Task-file strobes pass through only while the bank is closed.
    assign tf_rd = bus_rd & ~open_w;
    assign tf_wr = bus_wr & ~open_w;

    // Read data register: capture task-file or bank data on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (bus_rd) rdata_q <= open_w ? {{(DW-TW){1'b0}}, bank_val} : tf_rdata;
    end

    assign bus_rdata = rdata_q;
    assign bank_open = open_w;

    // R4
    property tf_latency_p;
        @(posedge clk) disable iff (!rst_n)
        (bus_rd && !open_w) |=> (bus_rdata == $past(tf_rdata));
    endproperty
    tf_latency_chk: assert property (tf_latency_p);
endmodule

// File: tb/sim_ide_bank_gate.sv
module sim_ide_bank_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, tf_rdata;
    logic        tf_rd, tf_wr, strap_clk = 1'b0, bank_open;
    logic [15:0] act_rd_tim, act_wr_tim;
    logic [6:0]  act_setup;

    int vec = 0, bad = 0;

    // Model state.
    bit       m_open;
    int       m_st;
    bit       m_sel;
    bit [6:0] m_setup, m_asu;
    bit [7:0] m_srd [2];
    bit [7:0] m_swr [2];
    bit [7:0] m_ard [2];
    bit [7:0] m_awr [2];

    always #10 clk = ~clk;

    assign tf_rdata = {bus_addr, 13'h0A5};

    ide_bank_gate u0 (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] m_read(input logic [2:0] a);
        if (!m_open) return {a, 13'h0A5};
        case (a)
            3'd0: return {8'h00, m_srd[m_sel]};
            3'd1: return {8'h00, m_swr[m_sel]};
            3'd5: return {15'h0, strap_clk};
            3'd6: return {8'h00, m_setup, m_sel};
            default: return 16'h0;
        endcase
    endfunction

    task automatic m_update(input bit rd, input bit wr, input logic [2:0] a,
                            input bit wide, input logic [15:0] d);
        bit step, key;
        if (m_open) begin
            if (wr) begin
                case (a)
                    3'd0: m_srd[m_sel] = d[7:0];
                    3'd1: m_swr[m_sel] = d[7:0];
                    3'd6: begin m_sel = d[0]; m_setup = d[7:1]; end
                    3'd3: if (!wide && d[7:0] == 8'h85) begin
                        m_ard[0] = m_srd[0]; m_ard[1] = m_srd[1];
                        m_awr[0] = m_swr[0]; m_awr[1] = m_swr[1];
                        m_asu = m_setup;
                    end
                    3'd2: if (!wide && d[7:0] == 8'h83) begin m_open = 0; m_st = 0; end
                    default: ;
                endcase
            end
        end else if (rd || wr) begin
            step = rd && wide && a == 3'd1;
            key  = wr && !wide && a == 3'd2 && d[7:0] == 8'h03;
            case (m_st)
                0: m_st = step ? 1 : 0;
                1: m_st = step ? 2 : 0;
                default: if (key) begin m_open = 1; m_st = 0; end
                         else m_st = step ? 1 : 0;
            endcase
        end
    endtask

    // One bus access; checks strobes, read data, open flag and outputs.
    task automatic acc(input bit rd, input bit wr, input logic [2:0] a, input bit wide,
                       input logic [15:0] d, input string tag);
        logic [15:0] exp_rd;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wide = wide; bus_wdata = d;
        #1;
        chk(m_open ? "R5 tf_rd quiet" : "R4 tf_rd pass", tf_rd, rd && !m_open);
        chk(m_open ? "R5 tf_wr quiet" : "R4 tf_wr pass", tf_wr, wr && !m_open);
        exp_rd = m_read(a);
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        m_update(rd, wr, a, wide, d);
        if (rd) chk({tag, " rdata"}, bus_rdata, exp_rd);
        chk({tag, " bank_open"}, bank_open, m_open);
        chk("R8 act_rd_tim", act_rd_tim, {m_ard[1], m_ard[0]});
        chk("R8 act_wr_tim", act_wr_tim, {m_awr[1], m_awr[0]});
        chk("R8 act_setup", act_setup, m_asu);
    endtask

    task automatic do_open();
        acc(1, 0, 3'd1, 1, 16'h0, "R2 step1");
        acc(1, 0, 3'd1, 1, 16'h0, "R2 step2");
        acc(0, 1, 3'd2, 0, 16'h0003, "R2 key");
    endtask

    task automatic do_shut();
        acc(0, 1, 3'd2, 0, 16'h0083, "R10 lock");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 bank_open", bank_open, 0);
        chk("R1 act_rd_tim", act_rd_tim, 0);
        chk("R1 act_wr_tim", act_wr_tim, 0);
        chk("R1 act_setup", act_setup, 0);

        // R4 closed window: every offset, both widths, both directions.
        for (int a = 0; a < 8; a++)
            for (int w = 0; w < 2; w++) begin
                acc(1, 0, 3'(a), w[0], 16'h0, "R4 closed read");
                acc(0, 1, 3'(a), w[0], 16'h1234, "R4 closed write");
            end

        // R3 break sweep: breaker after 0..2 valid steps, then key write.
        for (int p = 0; p < 3; p++)
            for (int a = 0; a < 8; a++)
                for (int w = 0; w < 2; w++)
                    for (int k = 0; k < 2; k++) begin
                        if (p < 2 && k == 0 && w == 1 && a == 1) continue;
                        if (p == 2 && k == 1 && w == 0 && a == 2) continue;
                        for (int s = 0; s < p; s++) acc(1, 0, 3'd1, 1, 16'h0, "R3 step");
                        acc(k == 0, k == 1, 3'(a), w[0], 16'h0003, "R3 breaker");
                        acc(0, 1, 3'd2, 0, 16'h0003, "R3 key after break");
                        if (m_open) do_shut();
                    end
        // R3 wrong key values at offset 2.
        foreach (m_srd[i]) begin end
        for (int v = 0; v < 4; v++) begin
            acc(1, 0, 3'd1, 1, 16'h0, "R3 step");
            acc(1, 0, 3'd1, 1, 16'h0, "R3 step");
            acc(0, 1, 3'd2, 0, (v == 3) ? 16'h0083 : 16'(v + 4), "R3 wrong key");
            chk("R3 wrong key stays closed", bank_open, 0);
        end
        // R3 restart: third wide read is a new first step.
        for (int n = 3; n < 6; n++) begin
            for (int s = 0; s < n; s++) acc(1, 0, 3'd1, 1, 16'h0, "R3 restart step");
            acc(0, 1, 3'd2, 0, 16'h0003, "R3 restart key");
            chk("R3 restart result", bank_open, (n % 2) == 0);
            if (m_open) do_shut();
        end

        // R2 open, R5 readback of all offsets and zero offsets.
        do_open();
        chk("R2 opened", bank_open, 1);
        for (int a = 0; a < 8; a++) acc(1, 0, 3'(a), 0, 16'h0, "R5 open read");

        // R6/R7/R8 programming sweep over both devices.
        for (int r = 0; r < 6; r++) begin
            for (int d = 0; d < 2; d++) begin
                logic [7:0] mv, rv, wv;
                mv = 8'((r * 37 + 5) << 1) | 8'(d);
                rv = 8'(r * 29 + d * 101 + 3);
                wv = 8'(r * 53 + d * 17 + 9);
                acc(0, 1, 3'd6, 0, {8'h0, mv}, "R6 misc write");
                acc(1, 0, 3'd6, 0, 16'h0, "R6 misc read");
                acc(0, 1, 3'd0, 0, {8'hFF, rv}, "R7 rtim write");
                acc(0, 1, 3'd1, 0, {8'hFF, wv}, "R7 wtim write");
                acc(1, 0, 3'd0, 1, 16'h0, "R7 rtim read");
                acc(1, 0, 3'd1, 1, 16'h0, "R7 wtim read");
            end
            // R8 non-commit values and widths change nothing.
            acc(0, 1, 3'd3, 0, 16'h0084, "R8 no commit value");
            acc(0, 1, 3'd3, 1, 16'h0085, "R8 no commit wide");
            acc(0, 1, 3'd3, 0, 16'h0085, "R8 commit");
        end

        // R9 strap readback and write ignored.
        for (int s = 0; s < 2; s++) begin
            strap_clk = s[0];
            acc(1, 0, 3'd5, 0, 16'h0, "R9 strap read");
            acc(0, 1, 3'd5, 0, 16'h00FE, "R9 strap write");
            acc(1, 0, 3'd5, 0, 16'h0, "R9 strap after write");
            acc(1, 0, 3'd6, 0, 16'h0, "R9 misc untouched");
        end

        // R10 non-lock writes at offset 2 keep the bank open.
        acc(0, 1, 3'd2, 1, 16'h0083, "R10 wide lock ignored");
        acc(0, 1, 3'd2, 0, 16'h0003, "R10 open key ignored");
        acc(0, 1, 3'd2, 0, 16'h0082, "R10 near key ignored");
        chk("R10 still open", bank_open, 1);
        do_shut();
        chk("R10 closed", bank_open, 0);
        acc(1, 0, 3'd0, 1, 16'h0, "R4 task file after lock");

        // R1 reset clears committed timing.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_open = 0; m_st = 0; m_sel = 0; m_setup = 0; m_asu = 0;
        for (int d = 0; d < 2; d++) begin m_srd[d] = 0; m_swr[d] = 0; m_ard[d] = 0; m_awr[d] = 0; end
        @(negedge clk);
        chk("R1 reset act_rd_tim", act_rd_tim, 0);
        chk("R1 reset act_wr_tim", act_wr_tim, 0);
        chk("R1 reset bank_open", bank_open, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule